// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between on-chip logic and an external asynchronous static RAM whose 32-bit data path is made of four independent 8-bit lanes. Every lane has its own active-low chip select and write enable. All lanes share one address bus and one output enable. The host issues single-beat reads or writes with a request/ready handshake. Each request carries a lane mask, so one request can touch the whole word, either 16-bit half, any single byte, or any other mix of lanes. The controller turns each request into a correctly timed memory cycle. Read data returns with a one-cycle valid strobe.

All timing comes from parameters. The clock period and the memory's nanosecond limits are given in picoseconds. From these the block derives, at elaboration, three cycle counts: read access, write strobe and bus turnaround. A write that follows a read gets turnaround cycles first. During those cycles the memory releases the shared data bus before the controller enables its own drivers. The memory-side data bus appears as separate drive-value, per-lane drive-enable and sample ports, so pad cells stay outside the block.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While idle, `rdy_o` is 1, every chip select and write enable and the output enable are high, and no lane drive enable is set.
- R2: A read asserts chip select (low) only on the lanes whose mask bit is 1, holds output enable low and every write enable high, and presents the latched address. This lasts exactly ACC_CYC = ceil(T_ACC_PS / CLK_PS) cycles, starting the cycle after acceptance.
- R3: In the cycle after the last access cycle, `rvalid_o` is 1 for exactly one cycle. Byte n of `rdata_o` (bits 8n+7:8n) then holds the sampled memory byte for selected lanes and zero for unselected lanes.
- R4: A write runs in three phases. First comes one setup cycle: chip select low on the selected lanes, write enables high, data driven. Next come WP_CYC strobe cycles, in which write enable is also low on the selected lanes. Last comes one hold cycle: chip selects and write enables high, data still driven. The block then returns to idle.
- R5: Output enable stays high in every cycle in which any write enable is low or any lane drive enable is set.
- R6: A write accepted when the previous accepted request was a read starts with TURN_CYC = ceil(T_TURN_PS / CLK_PS) cycles. During these cycles all strobes are high, no drivers are on and `rdy_o` is 0. No drive enable is set in the cycle after one with output enable low.
- R7: Lanes whose mask bit is 0 keep chip select and write enable high and their drive enable off for the whole request. A request with an all-zero mask strobes no lane and changes no stored data.
- R8: Address and drive data stay constant across every cycle in which any write enable is low.
- R9: WP_CYC is the larger of ceil(T_WP_PS / CLK_PS) and ceil(T_DW_PS / CLK_PS). Every cycle count is at least 1. Each write-enable strobe lasts at least WP_CYC cycles. Elaboration is rejected when a write cycle would be shorter than T_WC_PS or a count overflows its counter.
- R10: `rdy_o` is 0 throughout an active request. Request inputs that change while `rdy_o` is 0 are ignored. Address, data, direction and mask are captured only on a cycle with `req_i` and `rdy_o` both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request |
| rdy_o | output | 1 | Controller idle and able to accept |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (19) | Host word address |
| wdata_i | input | 32 | Host write data |
| lane_en_i | input | 4 | Lane mask, bit n selects byte n |
| rdata_o | output | 32 | Read data, unselected lanes zero |
| rvalid_o | output | 1 | One-cycle read-data-valid strobe |
| mem_addr_o | output | ADDR_W (19) | Shared memory address |
| mem_cs_n_o | output | 4 | Per-lane active-low chip select |
| mem_we_n_o | output | 4 | Per-lane active-low write enable |
| mem_oe_n_o | output | 1 | Shared active-low output enable |
| mem_dq_o | output | 32 | Value to drive on the data bus |
| mem_dq_oe_o | output | 4 | Per-lane drive enable for the data bus |
| mem_dq_i | input | 32 | Sampled data bus |

## Verification
The bench goes after a write issued directly after a read. A design that skips the turnaround would turn on its drivers while the memory is still driving the bus. A further scenario is a partial-lane read with garbage on the unselected lanes: a controller that fails to mask would return that garbage instead of zero. All-zero and split masks expose a write enable that leaks onto an unselected lane, which would corrupt a neighbouring byte. This shows up when that byte is read back later. Changing the request inputs while the block is busy catches a controller that re-latches address or data mid-cycle. Such a controller would write to the wrong location or produce an extra request.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_READ = 3'd1,
      ST_TURN = 3'd2,
      ST_WSET = 3'd3,
      ST_WPUL = 3'd4,
      ST_WHLD = 3'd5
   } ctl_state_t;

   // ceiling of a time over the clock period, never below one cycle
   function automatic int cyc_ceil(input int t_ps, input int clk_ps);
      int c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
   import sram_lane_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int ACC_CYC  = 3,
   parameter int WP_CYC   = 3,
   parameter int TURN_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             wr,
   input  logic             timer_last,
   output ctl_state_t       state,
   output logic             accept,
   output logic             capture,
   output logic             timer_load,
   output logic [CNT_W-1:0] timer_val
);

   localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC - 1);

   ctl_state_t state_q, state_d;
   logic       prev_rd_q;

   always_comb begin
      state_d    = state_q;
      accept     = 1'b0;
      capture    = 1'b0;
      timer_load = 1'b0;
      timer_val  = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (req) begin
               accept     = 1'b1;
               timer_load = 1'b1;
               if (!wr) begin
                  state_d   = ST_READ;
                  timer_val = ACC_LD;
               end else if (prev_rd_q) begin
                  state_d   = ST_TURN;
                  timer_val = TURN_LD;
               end else begin
                  state_d   = ST_WSET;
               end
            end
         end
         ST_READ: begin
            if (timer_last) begin
               capture = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_TURN: begin
            if (timer_last) state_d = ST_WSET;
         end
         ST_WSET: begin
            state_d    = ST_WPUL;
            timer_load = 1'b1;
            timer_val  = WP_LD;
         end
         ST_WPUL: begin
            if (timer_last) state_d = ST_WHLD;
         end
         ST_WHLD: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         prev_rd_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) prev_rd_q <= !wr;
      end
   end

   assign state = state_q;

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  ctl_state_t               state,
   input  logic                     accept,
   input  logic                     capture,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [LANES*LANE_W-1:0]  wdata_i,
   input  logic [LANES-1:0]         lane_en_i,
   input  logic [LANES*LANE_W-1:0]  mem_dq_i,
   output logic [ADDR_W-1:0]        mem_addr_o,
   output logic [LANES-1:0]         mem_cs_n_o,
   output logic [LANES-1:0]         mem_we_n_o,
   output logic                     mem_oe_n_o,
   output logic [LANES*LANE_W-1:0]  mem_dq_o,
   output logic [LANES-1:0]         mem_dq_oe_o,
   output logic [LANES*LANE_W-1:0]  rdata_o,
   output logic                     rvalid_o
);

   localparam int DATA_W = LANES * LANE_W;

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  mask_q;
   logic              rvalid_q;

   logic sel_phase, strobe_phase, drive_phase;

   assign sel_phase    = (state == ST_READ) || (state == ST_WSET) || (state == ST_WPUL);
   assign strobe_phase = (state == ST_WPUL);
   assign drive_phase  = (state == ST_WSET) || (state == ST_WPUL) || (state == ST_WHLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         wdata_q  <= '0;
         mask_q   <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= capture;
         if (accept) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            mask_q  <= lane_en_i;
         end
      end
   end

   for (genvar n = 0; n < LANES; n++) begin : g_lane
      logic [LANE_W-1:0] rbyte_q;

      assign mem_cs_n_o[n]  = !(mask_q[n] && sel_phase);
      assign mem_we_n_o[n]  = !(mask_q[n] && strobe_phase);
      assign mem_dq_oe_o[n] = mask_q[n] && drive_phase;
      assign mem_dq_o[n*LANE_W +: LANE_W] = wdata_q[n*LANE_W +: LANE_W];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rbyte_q <= '0;
         else if (capture)
            rbyte_q <= mask_q[n] ? mem_dq_i[n*LANE_W +: LANE_W] : '0;
      end

      assign rdata_o[n*LANE_W +: LANE_W] = rbyte_q;
   end

   assign mem_addr_o = addr_q;
   assign mem_oe_n_o = (state != ST_READ);
   assign rvalid_o   = rvalid_q;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W    = 19,
   parameter int LANES     = 4,
   parameter int LANE_W    = 8,
   parameter int CNT_W     = 8,
   parameter int CLK_PS    = 5000,
   parameter int T_ACC_PS  = 15000,
   parameter int T_WP_PS   = 12000,
   parameter int T_DW_PS   = 9000,
   parameter int T_WC_PS   = 15000,
   parameter int T_TURN_PS = 8000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_i,
   output logic                     rdy_o,
   input  logic                     wr_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic [LANES*LANE_W-1:0]  wdata_i,
   input  logic [LANES-1:0]         lane_en_i,
   output logic [LANES*LANE_W-1:0]  rdata_o,
   output logic                     rvalid_o,
   output logic [ADDR_W-1:0]        mem_addr_o,
   output logic [LANES-1:0]         mem_cs_n_o,
   output logic [LANES-1:0]         mem_we_n_o,
   output logic                     mem_oe_n_o,
   output logic [LANES*LANE_W-1:0]  mem_dq_o,
   output logic [LANES-1:0]         mem_dq_oe_o,
   input  logic [LANES*LANE_W-1:0]  mem_dq_i
);

   localparam int DATA_W   = LANES * LANE_W;
   localparam int ACC_CYC  = cyc_ceil(T_ACC_PS, CLK_PS);
   localparam int WP_CYC   = imax(cyc_ceil(T_WP_PS, CLK_PS), cyc_ceil(T_DW_PS, CLK_PS));
   localparam int TURN_CYC = cyc_ceil(T_TURN_PS, CLK_PS);
   localparam int CNT_MAX  = (1 << CNT_W) - 1;

   // elaboration-time parameter checks
   if (LANES < 1 || LANE_W < 1 || ADDR_W < 1) begin : g_bad_shape
      $error("sram_lane_ctrl: lane count, lane width and address width must be positive");
   end
   if (CLK_PS < 1) begin : g_bad_clk
      $error("sram_lane_ctrl: clock period must be positive");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cntw
      $error("sram_lane_ctrl: counter width out of range");
   end
   if (ACC_CYC - 1 > CNT_MAX || WP_CYC - 1 > CNT_MAX || TURN_CYC - 1 > CNT_MAX) begin : g_bad_cnt
      $error("sram_lane_ctrl: a derived cycle count does not fit the phase counter");
   end
   if ((WP_CYC + 2) * CLK_PS < T_WC_PS) begin : g_bad_wc
      $error("sram_lane_ctrl: write cycle shorter than the minimum cycle time");
   end

   ctl_state_t       state;
   logic             accept, capture, timer_load, timer_last;
   logic [CNT_W-1:0] timer_val;

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (timer_load),
      .load_val (timer_val),
      .last     (timer_last)
   );

   sram_ctl_fsm #(
      .CNT_W    (CNT_W),
      .ACC_CYC  (ACC_CYC),
      .WP_CYC   (WP_CYC),
      .TURN_CYC (TURN_CYC)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req_i),
      .wr         (wr_i),
      .timer_last (timer_last),
      .state      (state),
      .accept     (accept),
      .capture    (capture),
      .timer_load (timer_load),
      .timer_val  (timer_val)
   );

   sram_lane_path #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_path (
      .clk         (clk),
      .rst_n       (rst_n),
      .state       (state),
      .accept      (accept),
      .capture     (capture),
      .addr_i      (addr_i),
      .wdata_i     (wdata_i),
      .lane_en_i   (lane_en_i),
      .mem_dq_i    (mem_dq_i),
      .mem_addr_o  (mem_addr_o),
      .mem_cs_n_o  (mem_cs_n_o),
      .mem_we_n_o  (mem_we_n_o),
      .mem_oe_n_o  (mem_oe_n_o),
      .mem_dq_o    (mem_dq_o),
      .mem_dq_oe_o (mem_dq_oe_o),
      .rdata_o     (rdata_o),
      .rvalid_o    (rvalid_o)
   );

   assign rdy_o = (state == ST_IDLE);

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
   parameter int ADDR_W = 19,
   parameter int LANES  = 4,
   parameter int DATA_W = 32,
   parameter int WP_CYC = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rdy_o,
   input logic              rvalid_o,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [LANES-1:0]  mem_cs_n_o,
   input logic [LANES-1:0]  mem_we_n_o,
   input logic              mem_oe_n_o,
   input logic [DATA_W-1:0] mem_dq_o,
   input logic [LANES-1:0]  mem_dq_oe_o
);

   logic        strobe_any;
   logic [15:0] strobe_len_q;

   assign strobe_any = !(&mem_we_n_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         strobe_len_q <= '0;
      else if (strobe_any)
         strobe_len_q <= (strobe_len_q == 16'hFFFF) ? strobe_len_q : strobe_len_q + 1'b1;
      else
         strobe_len_q <= '0;
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_o |-> (&mem_cs_n_o && &mem_we_n_o && mem_oe_n_o && mem_dq_oe_o == '0));

   assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid_o |=> !rvalid_o);

   assert_oe_off_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_any || |mem_dq_oe_o) |-> mem_oe_n_o);

   assert_bus_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!mem_oe_n_o) |-> (mem_dq_oe_o == '0));

   assert_we_needs_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((~mem_we_n_o) & mem_cs_n_o) == '0);

   assert_stable_in_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_any && $past(strobe_any)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

   assert_strobe_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(strobe_any) && !strobe_any) |-> (strobe_len_q >= WP_CYC));

   assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&mem_cs_n_o) || |mem_dq_oe_o) |-> !rdy_o);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .LANES  (LANES),
   .DATA_W (DATA_W),
   .WP_CYC (WP_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rdy_o       (rdy_o),
   .rvalid_o    (rvalid_o),
   .mem_addr_o  (mem_addr_o),
   .mem_cs_n_o  (mem_cs_n_o),
   .mem_we_n_o  (mem_we_n_o),
   .mem_oe_n_o  (mem_oe_n_o),
   .mem_dq_o    (mem_dq_o),
   .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;

   // R9: counts worked out here from the default timing numbers
   // clock 5000 ps: access 15000 -> 3, strobe max(12000, 9000) -> 3, turnaround 8000 -> 2
   localparam int ACC  = 3;
   localparam int WP   = 3;
   localparam int TURN = 2;

   typedef struct {
      logic [3:0]  cs;
      logic [3:0]  we;
      logic [3:0]  doe;
      logic        oe;
      logic        rdy;
      logic        rv;
      logic [31:0] rd;
      logic [31:0] dq;
      logic [18:0] a;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        wr = 1'b0;
   logic [18:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [3:0]  lane_en = '0;
   logic        rdy, rvalid, oe_n;
   logic [31:0] rdata, dq_o;
   logic [31:0] dq_i = '0;
   logic [18:0] maddr;
   logic [3:0]  cs_n, we_n, dq_oe;

   exp_t        q[$];
   logic [31:0] mem [int];
   logic [31:0] exp_mem [int];
   logic [3:0]  prev_we = 4'hF;
   bit          last_rd = 1'b0;
   int          compared = 0;
   int          mismatched = 0;
   int          cycles = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   sram_lane_ctrl u_sram_lane_ctrl (
      .clk (clk), .rst_n (rst_n), .req_i (req), .rdy_o (rdy), .wr_i (wr),
      .addr_i (addr), .wdata_i (wdata), .lane_en_i (lane_en),
      .rdata_o (rdata), .rvalid_o (rvalid), .mem_addr_o (maddr),
      .mem_cs_n_o (cs_n), .mem_we_n_o (we_n), .mem_oe_n_o (oe_n),
      .mem_dq_o (dq_o), .mem_dq_oe_o (dq_oe), .mem_dq_i (dq_i)
   );

   function automatic exp_t idle_e(input string tag);
      exp_t e;
      e.cs = 4'hF; e.we = 4'hF; e.doe = 4'h0; e.oe = 1'b1; e.rdy = 1'b1;
      e.rv = 1'b0; e.rd = '0; e.dq = '0; e.a = '0; e.tag = tag;
      return e;
   endfunction

   function automatic logic [31:0] lane_bits(input logic [3:0] m);
      logic [31:0] r;
      for (int n = 0; n < 4; n++) r[n*8 +: 8] = {8{m[n]}};
      return r;
   endfunction

   function automatic logic [31:0] rd_word(input logic [18:0] a);
      return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 32'h0;
   endfunction

   task automatic cmp(input exp_t e);
      bit bad;
      bad = 1'b0;
      compared++;
      if (cs_n !== e.cs || we_n !== e.we || oe_n !== e.oe || dq_oe !== e.doe ||
          rdy !== e.rdy || rvalid !== e.rv) bad = 1'b1;
      if (e.cs != 4'hF && maddr !== e.a) bad = 1'b1;
      if (e.rv && rdata !== e.rd) bad = 1'b1;
      for (int n = 0; n < 4; n++)
         if (e.doe[n] && dq_o[n*8 +: 8] !== e.dq[n*8 +: 8]) bad = 1'b1;
      if (bad) begin
         mismatched++;
         $display("FAIL %s t=%0t actual cs=%h we=%h oe=%b doe=%h rdy=%b rv=%b rd=%h dq=%h a=%h expected cs=%h we=%h oe=%b doe=%h rdy=%b rv=%b rd=%h dq=%h a=%h",
                  e.tag, $time, cs_n, we_n, oe_n, dq_oe, rdy, rvalid, rdata, dq_o, maddr,
                  e.cs, e.we, e.oe, e.doe, e.rdy, e.rv, e.rd, e.dq, e.a);
      end
   endtask

   // memory model, bus sampling and per-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         cycles++;
         for (int n = 0; n < 4; n++) begin
            if (prev_we[n] == 1'b0 && we_n[n] == 1'b1) begin
               logic [31:0] w;
               w = mem.exists(int'(maddr)) ? mem[int'(maddr)] : 32'h0;
               w[n*8 +: 8] = dq_o[n*8 +: 8];
               mem[int'(maddr)] = w;
            end
         end
         prev_we = we_n;
         for (int n = 0; n < 4; n++) begin
            if (!cs_n[n] && !oe_n && we_n[n])
               dq_i[n*8 +: 8] = (mem.exists(int'(maddr)) ? mem[int'(maddr)] : 32'h0) >> (n*8);
            else
               dq_i[n*8 +: 8] = 8'hA5;
         end
         if (q.size() != 0) cmp(q.pop_front());
         else cmp(idle_e("R1"));
      end
   end

   task automatic run_op(input bit w, input logic [18:0] a, input logic [31:0] d,
                         input logic [3:0] m, input bit noise);
      exp_t e;
      do @(posedge clk); while (q.size() != 0);
      #1;
      req = 1'b1; wr = w; addr = a; wdata = d; lane_en = m;
      q.push_back(idle_e("R10"));
      if (!w) begin
         for (int i = 0; i < ACC; i++) begin
            e = idle_e("R2");
            e.cs = ~m; e.oe = 1'b0; e.rdy = 1'b0; e.a = a;
            q.push_back(e);
         end
         e = idle_e("R3");
         e.rv = 1'b1; e.rd = rd_word(a) & lane_bits(m);
         q.push_back(e);
         last_rd = 1'b1;
      end else begin
         if (last_rd) begin
            for (int i = 0; i < TURN; i++) begin
               e = idle_e("R6");
               e.rdy = 1'b0;
               q.push_back(e);
            end
         end
         e = idle_e(m == 4'h0 ? "R7" : "R4");
         e.cs = ~m; e.doe = m; e.rdy = 1'b0; e.dq = d; e.a = a;
         q.push_back(e);
         for (int i = 0; i < WP; i++) begin
            e.we = ~m; e.tag = (m == 4'h0) ? "R7" : "R5";
            q.push_back(e);
         end
         e.cs = 4'hF; e.we = 4'hF; e.tag = "R4";
         q.push_back(e);
         exp_mem[int'(a)] = (rd_word(a) & ~lane_bits(m)) | (d & lane_bits(m));
         last_rd = 1'b0;
      end
      @(posedge clk); #1;
      if (noise) begin
         // R10: inputs change while busy and must be ignored
         wr = ~w; addr = ~a; wdata = ~d; lane_en = ~m;
         @(posedge clk); #1;
      end
      req = 1'b0;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (3) @(posedge clk);                     // R1 reset state
      run_op(1'b1, 19'h00010, 32'h11223344, 4'hF, 1'b0);  // R4 full word
      run_op(1'b0, 19'h00010, 32'h0, 4'hF, 1'b0);          // R2 R3
      run_op(1'b1, 19'h00010, 32'hAABBCCDD, 4'h0, 1'b0);   // R7 empty mask
      run_op(1'b0, 19'h00010, 32'h0, 4'hF, 1'b0);
      run_op(1'b1, 19'h7FFFF, 32'hCAFE0000, 4'hC, 1'b1);   // R6 after read, R10 noise
      run_op(1'b1, 19'h7FFFF, 32'h0000BEEF, 4'h3, 1'b0);
      run_op(1'b0, 19'h7FFFF, 32'h0, 4'hF, 1'b0);
      run_op(1'b0, 19'h7FFFF, 32'h0, 4'h4, 1'b0);          // R3 byte lane, others zero
      run_op(1'b0, 19'h7FFFF, 32'h0, 4'hA, 1'b0);
      run_op(1'b1, 19'h00000, 32'h5A5A5A5A, 4'h2, 1'b1);   // R7 single lane, R8 held by checker
      run_op(1'b1, 19'h00000, 32'h01020304, 4'h9, 1'b0);
      run_op(1'b0, 19'h00000, 32'h0, 4'hF, 1'b0);
      run_op(1'b0, 19'h00000, 32'h0, 4'h0, 1'b0);          // R7 read with empty mask
      do @(posedge clk); while (q.size() != 0);
      repeat (4) @(posedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         mismatched++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule